// File: doc/BRIEF.md
# Programmable CPU Clock Prescaler

This block turns one fast reference clock into a processor clock-enable. It does not make a new clock. It produces a pulse one reference cycle wide, once per output period. The enabled logic runs on the reference clock and advances only on those pulses. The period is the product of two factors:

- **Base ratio.** A two-bit rate selector picks one of three ratios: 4, 6 or 8. With a 39.3216 MHz reference these give 9.8304, 6.5536 and 4.9152 MHz.
- **Post-divider.** A three-bit code multiplies the base ratio by a power of two. Each step of the code doubles the period. The factor stops at 64, so the two highest codes give the same rate.

The selector value 2'b11 is not a legal setting. When it is applied, the block runs at the slowest base ratio and raises a flag.

A new setting is picked up only on the reference edge that issues a pulse. The period then running always completes at its old length, and the setting captured with the pulse sets the length of the next period. The processor can therefore rewrite its own clock speed at any time without ever seeing a shortened cycle.

Top module: `ckp_cpu_prescaler`

## Requirements
- R1: With `rate_sel` = 2'b10, the spacing between enable pulses is 4 × 2^min(`div_code`,6) reference cycles.
- R2: With `rate_sel` = 2'b01, the spacing between enable pulses is 6 × 2^min(`div_code`,6) reference cycles.
- R3: With `rate_sel` = 2'b00, the spacing between enable pulses is 8 × 2^min(`div_code`,6) reference cycles.
- R4: Each increment of `div_code` from 3'b000 to 3'b110 doubles the period. Codes 3'b110 and 3'b111 give the same period, and no period exceeds 512 cycles.
- R5: With `rate_sel` = 2'b11, the block uses the base ratio 8. `bad_rate` is high from the first edge after 2'b11 is applied and low from the first edge after a legal value is applied.
- R6: `cpu_en` is never high for two consecutive reference cycles.
- R7: The setting is sampled only on the edge that raises `cpu_en`. The following period has the length of the sampled setting. A change made mid-period leaves the current period unchanged.
- R8: While `rst_n` is low, `cpu_en` and `bad_rate` are low. The block restarts at ratio 8 with code 3'b000, and the first pulse goes high on the 8th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Base ratio select: 10 = /4, 01 = /6, 00 = /8, 11 = illegal (/8) |
| div_code | input | 3 | Power-of-two post-divider code, saturating at 6 |
| cpu_en | output | 1 | One-cycle clock-enable pulse per output period |
| bad_rate | output | 1 | High while the illegal selector value is applied |

## Verification
The hardest situation to reach is a setting change that lands in the middle of a period. Such a change must not touch the period already running, yet must apply in full to the next one. To reach it, the bench first locks onto a pulse. It then changes the setting a few cycles later, from a long period to a short one and from a short period to a long one. It measures two consecutive gaps: the first must keep the old length and the second must take the new one. The bound checker separately compares every gap against the setting seen on the edge of the previous pulse.

// File: rtl/ckp_pkg.sv
package ckp_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_BAD  = 2'b11
    } rate_sel_e;

endpackage

// File: rtl/ckp_rate_decode.sv
module ckp_rate_decode #(
    parameter int BASE_FAST = 4,
    parameter int BASE_MID  = 6,
    parameter int BASE_SLOW = 8,
    parameter int CODE_W    = 3,
    parameter int MAX_SHIFT = 6,
    parameter int CNT_W     = 9
) (
    input  logic [1:0]        rate_sel,
    input  logic [CODE_W-1:0] div_code,
    output logic [CNT_W-1:0]  last_count,
    output logic              illegal
);
    import ckp_pkg::*;

    localparam int SH_W = $clog2(MAX_SHIFT + 1);

    logic [CNT_W-1:0] base_w;
    logic [SH_W-1:0]  shift_w;
    rate_sel_e        sel;

    assign sel = rate_sel_e'(rate_sel);

    always_comb begin
        illegal = 1'b0;
        unique case (sel)
            RATE_FAST: base_w = CNT_W'(BASE_FAST);
            RATE_MID:  base_w = CNT_W'(BASE_MID);
            RATE_SLOW: base_w = CNT_W'(BASE_SLOW);
            default: begin
                base_w  = CNT_W'(BASE_SLOW);
                illegal = 1'b1;
            end
        endcase
    end

    generate
        if ((1 << CODE_W) - 1 > MAX_SHIFT) begin : g_sat
            always_comb begin
                if (int'(div_code) > MAX_SHIFT) shift_w = SH_W'(MAX_SHIFT);
                else                            shift_w = SH_W'(div_code);
            end
        end else begin : g_nosat
            always_comb shift_w = SH_W'(div_code);
        end
    endgenerate

    assign last_count = (base_w << shift_w) - CNT_W'(1);

endmodule

// File: rtl/ckp_period_counter.sv
module ckp_period_counter #(
    parameter int CNT_W      = 9,
    parameter int RESET_LAST = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_last,
    output logic             pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == st_q.last) begin
            st_d.cnt   = '0;
            st_d.last  = next_last;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.last  <= CNT_W'(RESET_LAST);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

endmodule

// File: rtl/ckp_cpu_prescaler.sv
module ckp_cpu_prescaler #(
    parameter int BASE_FAST = 4,
    parameter int BASE_MID  = 6,
    parameter int BASE_SLOW = 8,
    parameter int CODE_W    = 3,
    parameter int MAX_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic [CODE_W-1:0] div_code,
    output logic              cpu_en,
    output logic              bad_rate
);
    localparam int MAX_PERIOD = BASE_SLOW << MAX_SHIFT;
    localparam int CNT_W      = $clog2(MAX_PERIOD);
    localparam int RESET_LAST = BASE_SLOW - 1;

    typedef struct packed {
        logic bad;
    } flag_state_t;

    logic [CNT_W-1:0] next_last;
    logic             illegal;
    flag_state_t      fl_d, fl_q;

    ckp_rate_decode #(
        .BASE_FAST (BASE_FAST),
        .BASE_MID  (BASE_MID),
        .BASE_SLOW (BASE_SLOW),
        .CODE_W    (CODE_W),
        .MAX_SHIFT (MAX_SHIFT),
        .CNT_W     (CNT_W)
    ) u_decode (
        .rate_sel   (rate_sel),
        .div_code   (div_code),
        .last_count (next_last),
        .illegal    (illegal)
    );

    ckp_period_counter #(
        .CNT_W      (CNT_W),
        .RESET_LAST (RESET_LAST)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_last (next_last),
        .pulse     (cpu_en)
    );

    always_comb begin
        fl_d     = fl_q;
        fl_d.bad = illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign bad_rate = fl_q.bad;

endmodule

// File: rtl/ckp_prescaler_chk.sv
module ckp_prescaler_chk #(
    parameter int CODE_W    = 3,
    parameter int GAP_W     = 10,
    parameter int GAP_LIMIT = 512,
    parameter int GAP_RESET = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rate_sel,
    input logic [CODE_W-1:0] div_code,
    input logic              cpu_en,
    input logic              bad_rate
);
    logic [GAP_W-1:0]  gap_q;
    logic [GAP_W-1:0]  exp_q;
    logic [1:0]        sel_q;
    logic [CODE_W-1:0] code_q;

    function automatic logic [GAP_W-1:0] ref_gap(input logic [1:0] s, input logic [CODE_W-1:0] c);
        int b;
        int k;
        if (s == 2'b10)      b = 4;
        else if (s == 2'b01) b = 6;
        else                 b = 8;
        k = (int'(c) > 6) ? 6 : int'(c);
        return GAP_W'(b * (1 << k));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            exp_q  <= GAP_W'(GAP_RESET);
            sel_q  <= 2'b00;
            code_q <= '0;
        end else begin
            sel_q  <= rate_sel;
            code_q <= div_code;
            if (cpu_en) begin
                gap_q <= GAP_W'(1);
                exp_q <= ref_gap(sel_q, code_q);
            end else if (gap_q != {GAP_W{1'b1}}) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |=> !cpu_en);  // R6

    AST_GAP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> gap_q == exp_q);  // R7

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gap_q) <= GAP_LIMIT);  // R4

    AST_BAD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_rate) |-> $past(rate_sel) == 2'b11);  // R5

    AST_BAD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bad_rate) |-> $past(rate_sel) != 2'b11);  // R5

endmodule

bind ckp_cpu_prescaler ckp_prescaler_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .div_code (div_code),
    .cpu_en   (cpu_en),
    .bad_rate (bad_rate)
);

// File: tb/tb_ckp_cpu_prescaler.sv
module tb_ckp_cpu_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [2:0] div_code = 3'b000;
    logic       cpu_en;
    logic       bad_rate;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ckp_cpu_prescaler dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .div_code (div_code),
        .cpu_en   (cpu_en),
        .bad_rate (bad_rate)
    );

    // entry: {sel[1:0], code[2:0], gap[9:0], bad}
    localparam int NV = 32;
    localparam logic [15:0] VEC [NV] = '{
        {2'b10, 3'd0, 10'd4,   1'b0}, {2'b10, 3'd1, 10'd8,   1'b0},
        {2'b10, 3'd2, 10'd16,  1'b0}, {2'b10, 3'd3, 10'd32,  1'b0},
        {2'b10, 3'd4, 10'd64,  1'b0}, {2'b10, 3'd5, 10'd128, 1'b0},
        {2'b10, 3'd6, 10'd256, 1'b0}, {2'b10, 3'd7, 10'd256, 1'b0},
        {2'b01, 3'd0, 10'd6,   1'b0}, {2'b01, 3'd1, 10'd12,  1'b0},
        {2'b01, 3'd2, 10'd24,  1'b0}, {2'b01, 3'd3, 10'd48,  1'b0},
        {2'b01, 3'd4, 10'd96,  1'b0}, {2'b01, 3'd5, 10'd192, 1'b0},
        {2'b01, 3'd6, 10'd384, 1'b0}, {2'b01, 3'd7, 10'd384, 1'b0},
        {2'b00, 3'd0, 10'd8,   1'b0}, {2'b00, 3'd1, 10'd16,  1'b0},
        {2'b00, 3'd2, 10'd32,  1'b0}, {2'b00, 3'd3, 10'd64,  1'b0},
        {2'b00, 3'd4, 10'd128, 1'b0}, {2'b00, 3'd5, 10'd256, 1'b0},
        {2'b00, 3'd6, 10'd512, 1'b0}, {2'b00, 3'd7, 10'd512, 1'b0},
        {2'b11, 3'd0, 10'd8,   1'b1}, {2'b11, 3'd1, 10'd16,  1'b1},
        {2'b11, 3'd2, 10'd32,  1'b1}, {2'b11, 3'd3, 10'd64,  1'b1},
        {2'b11, 3'd4, 10'd128, 1'b1}, {2'b11, 3'd5, 10'd256, 1'b1},
        {2'b11, 3'd6, 10'd512, 1'b1}, {2'b11, 3'd7, 10'd512, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_en();
        do @(negedge clk); while (!cpu_en);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_en);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        int g;
        string tag;

        // R8: reset state and first pulse
        repeat (3) @(negedge clk);
        check("R8 en in reset", int'(cpu_en), 0);
        check("R8 bad in reset", int'(bad_rate), 0);
        rst_n = 1'b1;
        gap(g);
        check("R8 first pulse", g, 8);
        @(negedge clk);
        check("R6 pulse width", int'(cpu_en), 0);

        // R1 R2 R3 R4 R5: all settings
        foreach (VEC[i]) begin
            rate_sel = VEC[i][15:14];
            div_code = VEC[i][13:11];
            wait_en();
            gap(g);
            case (VEC[i][15:14])
                2'b10:   tag = "R1";
                2'b01:   tag = "R2";
                2'b00:   tag = "R3";
                default: tag = "R5";
            endcase
            if (VEC[i][13:11] >= 3'd6) tag = {tag, "/R4 saturate"};
            check(tag, g, int'(VEC[i][10:1]));
            check("R5 flag", int'(bad_rate), int'(VEC[i][0]));
        end

        // R5: flag clears after a legal value
        rate_sel = 2'b10;
        div_code = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R5 flag clear", int'(bad_rate), 0);

        // R7: long to short, changed mid-period
        rate_sel = 2'b00;
        div_code = 3'd2;
        wait_en();
        wait_en();
        repeat (5) @(negedge clk);
        rate_sel = 2'b10;
        div_code = 3'd0;
        g = 5;
        begin
            int r;
            gap(r);
            g += r;
        end
        check("R7 old period kept", g, 32);
        gap(g);
        check("R7 new period", g, 4);

        // R7: short to long, changed one cycle after a pulse
        wait_en();
        @(negedge clk);
        rate_sel = 2'b00;
        div_code = 3'd7;
        begin
            int r;
            gap(r);
            check("R7 short kept", r + 1, 4);
        end
        gap(g);
        check("R7 long applied", g, 512);

        // R6: pulse width at fastest rate
        rate_sel = 2'b10;
        div_code = 3'd0;
        wait_en();
        wait_en();
        @(negedge clk);
        check("R6 single cycle", int'(cpu_en), 0);

        // R8: reset mid-run returns to slowest default
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 en cleared", int'(cpu_en), 0);
        rst_n = 1'b1;
        gap(g);
        check("R8 restart period", g, 8);

        finish_run();
    end
endmodule